// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a 64-bit watchdog that sits behind a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software first sets up a period, a starting count and the two control words. It then arms the watchdog by writing two key values, in a fixed order, into the key field of the watchdog control word. While the watchdog is armed, software must repeat the same two-key handshake often enough to restart the count. If the count reaches the programmed 64-bit period first, the block raises a one-cycle reset pulse and sets a sticky timeout flag. The watchdog then stays expired until a system reset.

From the first key onward, all configuration writes are ignored, apart from the key field and the write-one-to-clear flag bit. The control sequence is a five-state machine:

- `ST_IDLE` is the unarmed state, where configuration is writable.
- `ST_PREACT` means the first key has been accepted with the enable bit set.
- `ST_ACTIVE` means the watchdog is counting and waiting for the first service key.
- `ST_SERVICE` means the first service key has been seen.
- `ST_EXPIRED` is the terminal state after a timeout.

The transitions are:

- **arm-1**: `ST_IDLE` to `ST_PREACT`.
- **arm-2**: `ST_PREACT` to `ST_ACTIVE`.
- **arm-abort**: `ST_PREACT` to `ST_IDLE`.
- **svc-1**: `ST_ACTIVE` to `ST_SERVICE`.
- **svc-2**: `ST_SERVICE` to `ST_ACTIVE`, which also clears the count.
- **svc-abort**: `ST_SERVICE` to `ST_ACTIVE`, leaving the count alone.
- **expire**: from `ST_ACTIVE` or `ST_SERVICE` to `ST_EXPIRED`.

Top module: `kwd_top`

## Requirements
- R1: A synchronous active-low reset clears every register, the timeout flag and the reset pulse, and puts the machine in `ST_IDLE`. After reset, every address reads 0.
- R2: The register map is as follows. Address 0 is the counter low word and address 1 the counter high word. Address 2 is the period low word and address 3 the period high word. Address 4 is the timer control word and address 5 the global control word. Address 6 is the watchdog control word, and address 7 reads 0. In `ST_IDLE`, writes to addresses 0–5 store the full 32-bit word, which reads back unchanged. Address 6 reads bit 15 as the timeout flag and bit 14 as enabled (1 in every state except `ST_IDLE`), with all other bits 0.
- R3: In `ST_IDLE`, a write to address 6 with bits 31:16 = 0xA5C6 and bit 14 = 1 moves to `ST_PREACT`. Any other write to address 6 leaves the machine in `ST_IDLE`.
- R4: In `ST_PREACT`, a write to address 6 with key 0xDA7E moves to `ST_ACTIVE`. A write with any other key returns to `ST_IDLE`.
- R5: The count advances only in `ST_ACTIVE` or `ST_SERVICE`, and only when global control bits 3:0 = 4'b1011 and timer control bits 7:6 are non-zero. It then advances by one per clock as a single 64-bit value, carrying from the low word into the high word. Otherwise the count holds.
- R6: In every state except `ST_IDLE`, writes to addresses 0–5 have no effect.
- R7: In `ST_ACTIVE`, key 0xA5C6 moves to `ST_SERVICE`. In `ST_SERVICE`, key 0xDA7E clears the 64-bit count to 0 and returns to `ST_ACTIVE`.
- R8: In `ST_SERVICE`, any key other than 0xDA7E returns to `ST_ACTIVE` and the count keeps running. In `ST_ACTIVE`, a key other than 0xA5C6 has no effect.
- R9: When the count is advancing and equals the 64-bit period, the reset pulse is high for exactly the next cycle and the timeout flag sets. This timeout takes priority over a service key written in the same cycle.
- R10: After a timeout the machine stays in `ST_EXPIRED` until reset. In that state the count is frozen and key writes have no effect.
- R11: The timeout flag changes only in three ways: it clears on reset, it sets on a timeout, and it clears when address 6 is written with bit 15 = 1. A write with bit 15 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_reset_o | output | 1 | One-cycle watchdog reset pulse |
| wd_timeout_o | output | 1 | Sticky timeout flag |

## Verification
The bench goes after the handshake paths that end in a wrong key. An aborted arming that stayed locked would refuse the period rewrite that follows. A service that accepted a lone second key would reset the count when it should keep running. It also probes the lock, where a leaky write would change the period readback. It probes the carry across the counter halves, where a design that got it wrong would never reach a period with a non-zero high word. Finally, it probes the expired state: a design that still honoured keys there would clear the frozen count, and one that pulsed for more than a cycle would be seen by the per-cycle pulse comparison.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREACT,
        ST_ACTIVE,
        ST_SERVICE,
        ST_EXPIRED
    } kwd_state_e;

    localparam logic [2:0] A_CNT_LO = 3'd0;
    localparam logic [2:0] A_CNT_HI = 3'd1;
    localparam logic [2:0] A_PER_LO = 3'd2;
    localparam logic [2:0] A_PER_HI = 3'd3;
    localparam logic [2:0] A_TCTL   = 3'd4;
    localparam logic [2:0] A_GCTL   = 3'd5;
    localparam logic [2:0] A_WCTL   = 3'd6;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;

    localparam int KEY_LSB  = 16;
    localparam int FLAG_BIT = 15;
    localparam int EN_BIT   = 14;

    localparam logic [3:0] GCTL_WDOG = 4'b1011;

endpackage

// File: rtl/kwd_cfg_regs.sv
module kwd_cfg_regs
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  locked,
    output logic [2*DATA_W-1:0]   per_q,
    output logic [DATA_W-1:0]     tctl_q,
    output logic [DATA_W-1:0]     gctl_q,
    output logic                  cfg_ok
);

    localparam int HALVES = 2;

    logic wr_ok;
    assign wr_ok = we && !locked;

    for (genvar h = 0; h < HALVES; h++) begin : g_per
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                per_q[h*DATA_W +: DATA_W] <= '0;
            end else if (wr_ok && addr == ADDR_W'(A_PER_LO + h)) begin
                per_q[h*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tctl_q <= '0;
            gctl_q <= '0;
        end else if (wr_ok) begin
            if (addr == ADDR_W'(A_TCTL)) tctl_q <= wdata;
            if (addr == ADDR_W'(A_GCTL)) gctl_q <= wdata;
        end
    end

    assign cfg_ok = (gctl_q[3:0] == GCTL_WDOG) && (tctl_q[7:6] != 2'b00);

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  locked,
    input  logic                  clear,
    input  logic                  advance,
    input  logic [2*DATA_W-1:0]   per_i,
    output logic [2*DATA_W-1:0]   cnt_q,
    output logic                  at_limit
);

    localparam int HALVES = 2;
    localparam int CNT_W  = HALVES * DATA_W;

    logic [CNT_W-1:0]  load_val;
    logic [HALVES-1:0] load_hit;

    for (genvar h = 0; h < HALVES; h++) begin : g_load
        assign load_hit[h] = we && !locked && (addr == ADDR_W'(A_CNT_LO + h));
        assign load_val[h*DATA_W +: DATA_W] =
            load_hit[h] ? wdata : cnt_q[h*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (|load_hit) begin
            cnt_q <= load_val;
        end
    end

    assign at_limit = (cnt_q == per_i);

endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [15:0] key_val,
    input  logic        en_bit,
    input  logic        flag_clr,
    input  logic        hit,
    output kwd_state_e  state_q,
    output logic        locked,
    output logic        armed,
    output logic        svc_clear,
    output logic        wd_pulse,
    output logic        wd_flag
);

    kwd_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (key_wr && key_val == KEY_FIRST && en_bit) state_d = ST_PREACT;
            end
            ST_PREACT: begin
                if (key_wr) state_d = (key_val == KEY_SECOND) ? ST_ACTIVE : ST_IDLE;
            end
            ST_ACTIVE: begin
                if (hit)                                   state_d = ST_EXPIRED;
                else if (key_wr && key_val == KEY_FIRST)   state_d = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (hit)         state_d = ST_EXPIRED;
                else if (key_wr) state_d = ST_ACTIVE;
            end
            ST_EXPIRED: begin
                state_d = ST_EXPIRED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_pulse <= 1'b0;
            wd_flag  <= 1'b0;
        end else begin
            wd_pulse <= hit;
            if (hit)                      wd_flag <= 1'b1;
            else if (key_wr && flag_clr)  wd_flag <= 1'b0;
        end
    end

    assign locked    = (state_q != ST_IDLE);
    assign armed     = (state_q == ST_ACTIVE) || (state_q == ST_SERVICE);
    assign svc_clear = (state_q == ST_SERVICE) && key_wr
                       && (key_val == KEY_SECOND) && !hit;

endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_o,
    output logic              wd_timeout_o
);

    localparam int CNT_W = 2 * DATA_W;

    kwd_state_e        state_q;
    logic              locked, armed, svc_clear, cfg_ok;
    logic              at_limit, count_en, hit, advance, key_wr;
    logic [CNT_W-1:0]  per_q, cnt_q;
    logic [DATA_W-1:0] tctl_q, gctl_q;

    assign key_wr   = bus_we && (bus_addr == ADDR_W'(A_WCTL));
    assign count_en = armed && cfg_ok;
    assign hit      = count_en && at_limit;
    assign advance  = count_en && !hit;

    kwd_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .locked (locked),
        .per_q  (per_q),
        .tctl_q (tctl_q),
        .gctl_q (gctl_q),
        .cfg_ok (cfg_ok)
    );

    kwd_counter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .locked   (locked),
        .clear    (svc_clear),
        .advance  (advance),
        .per_i    (per_q),
        .cnt_q    (cnt_q),
        .at_limit (at_limit)
    );

    kwd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_val   (bus_wdata[KEY_LSB +: 16]),
        .en_bit    (bus_wdata[EN_BIT]),
        .flag_clr  (bus_wdata[FLAG_BIT]),
        .hit       (hit),
        .state_q   (state_q),
        .locked    (locked),
        .armed     (armed),
        .svc_clear (svc_clear),
        .wd_pulse  (wd_reset_o),
        .wd_flag   (wd_timeout_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CNT_LO): bus_rdata = cnt_q[DATA_W-1:0];
            ADDR_W'(A_CNT_HI): bus_rdata = cnt_q[CNT_W-1:DATA_W];
            ADDR_W'(A_PER_LO): bus_rdata = per_q[DATA_W-1:0];
            ADDR_W'(A_PER_HI): bus_rdata = per_q[CNT_W-1:DATA_W];
            ADDR_W'(A_TCTL):   bus_rdata = tctl_q;
            ADDR_W'(A_GCTL):   bus_rdata = gctl_q;
            ADDR_W'(A_WCTL): begin
                bus_rdata[FLAG_BIT] = wd_timeout_o;
                bus_rdata[EN_BIT]   = locked;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                wd_reset_o,
    input logic                wd_timeout_o,
    input kwd_state_e          state_q,
    input logic [2*DATA_W-1:0] per_q,
    input logic [2*DATA_W-1:0] cnt_q
);

    logic key_wr;
    assign key_wr = bus_we && (bus_addr == ADDR_W'(A_WCTL));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_o |=> !wd_reset_o);

    assert_pulse_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_o |-> wd_timeout_o);

    assert_flag_clear_only_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wd_timeout_o) && $past(rst_n)) |-> $past(key_wr && bus_wdata[FLAG_BIT]));

    assert_period_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(per_q));

    assert_expired_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED) |=> (state_q == ST_EXPIRED) && $stable(cnt_q));

    assert_service_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && key_wr && bus_wdata[KEY_LSB +: 16] == KEY_SECOND)
        |=> (cnt_q == '0) || (state_q == ST_EXPIRED));

    assert_idle_holds_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !bus_we) |=> $stable(cnt_q));

endmodule

bind kwd_top kwd_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_kwd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .wd_reset_o   (wd_reset_o),
    .wd_timeout_o (wd_timeout_o),
    .state_q      (state_q),
    .per_q        (per_q),
    .cnt_q        (cnt_q)
);

// File: tb/kwd_top_bench.sv
module kwd_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_reset_o, wd_timeout_o;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    localparam bit [15:0] K1 = 16'hA5C6;
    localparam bit [15:0] K2 = 16'hDA7E;

    always #10 clk = ~clk;

    kwd_top u_kwd_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wd_reset_o   (wd_reset_o),
        .wd_timeout_o (wd_timeout_o)
    );

    // behavioural reference: 0 idle, 1 pre-active, 2 active, 3 service, 4 expired
    int        m_st = 0;
    bit [63:0] m_cnt = 0, m_per = 0;
    bit [31:0] m_tctl = 0, m_gctl = 0;
    bit        m_flag = 0, m_pulse = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 0; m_tctl = 0; m_gctl = 0;
            m_flag = 0; m_pulse = 0;
        end else begin
            bit        on, hit, kw;
            bit [15:0] key;
            int        ns;
            on  = (m_st == 2 || m_st == 3) && m_gctl[3:0] == 4'b1011 && m_tctl[7:6] != 0;
            hit = on && (m_cnt == m_per);
            kw  = bus_we && bus_addr == 3'd6;
            key = bus_wdata[31:16];
            ns  = m_st;
            if (hit) ns = 4;
            else if (kw) begin
                if (m_st == 0 && key == K1 && bus_wdata[14]) ns = 1;
                else if (m_st == 1) ns = (key == K2) ? 2 : 0;
                else if (m_st == 2 && key == K1) ns = 3;
                else if (m_st == 3) ns = 2;
            end
            if (hit) ;
            else if (kw && m_st == 3 && key == K2) m_cnt = 0;
            else if (on) m_cnt = m_cnt + 1;
            else if (m_st == 0 && bus_we && bus_addr == 3'd0) m_cnt[31:0] = bus_wdata;
            else if (m_st == 0 && bus_we && bus_addr == 3'd1) m_cnt[63:32] = bus_wdata;
            if (m_st == 0 && bus_we) begin
                if (bus_addr == 3'd2) m_per[31:0]  = bus_wdata;
                if (bus_addr == 3'd3) m_per[63:32] = bus_wdata;
                if (bus_addr == 3'd4) m_tctl = bus_wdata;
                if (bus_addr == 3'd5) m_gctl = bus_wdata;
            end
            if (hit) m_flag = 1;
            else if (kw && bus_wdata[15]) m_flag = 0;
            m_pulse = hit;
            m_st = ns;
        end
    end

    function automatic bit [31:0] m_read(bit [2:0] a);
        case (a)
            3'd0: return m_cnt[31:0];
            3'd1: return m_cnt[63:32];
            3'd2: return m_per[31:0];
            3'd3: return m_per[63:32];
            3'd4: return m_tctl;
            3'd5: return m_gctl;
            3'd6: return {16'h0, m_flag, (m_st != 0), 14'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk({cur_req, " pulse"}, {31'h0, wd_reset_o}, {31'h0, m_pulse});
            chk({cur_req, " flag"},  {31'h0, wd_timeout_o}, {31'h0, m_flag});
            chk({cur_req, " rdata"}, bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(bit [2:0] a, bit [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic rd(bit [2:0] a, output bit [31:0] v);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [31:0] v;
        int pulses;
        repeat (2) @(posedge clk);
        chk_on = 1'b1;
        #2 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk("R1 reset read", v, 32'h0);
        end

        // R2: configuration writes in idle
        cur_req = "R2";
        wr(3'd2, 32'd40); wr(3'd3, 32'd0); wr(3'd4, 32'h80);
        wr(3'd5, 32'hB); wr(3'd0, 32'd5); wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 period lo", v, 32'd40);
        rd(3'd5, v); chk("R2 global ctl", v, 32'hB);
        rd(3'd0, v); chk("R2 count lo", v, 32'd5);
        rd(3'd7, v); chk("R2 unused addr", v, 32'h0);

        // R3: malformed first steps stay idle
        cur_req = "R3";
        wr(3'd6, {K1, 16'h0000}); rd(3'd6, v); chk("R3 no enable bit", v, 32'h0);
        wr(3'd6, {16'h1234, 16'h4000}); rd(3'd6, v); chk("R3 wrong key", v, 32'h0);

        // R4: aborted arming returns to idle and unlocks
        cur_req = "R4";
        wr(3'd6, {K1, 16'h4000}); rd(3'd6, v); chk("R4 pre-active", v, 32'h4000);
        wr(3'd6, {16'h0BAD, 16'h4000}); rd(3'd6, v); chk("R4 abort", v, 32'h0);
        wr(3'd2, 32'd300); rd(3'd2, v); chk("R4 unlocked again", v, 32'd300);
        wr(3'd0, 32'd0);
        wr(3'd6, {K1, 16'h4000}); wr(3'd6, {K2, 16'h4000});
        rd(3'd6, v); chk("R4 active", v, 32'h4000);

        // R5: counting
        cur_req = "R5";
        rd(3'd0, v);
        begin
            bit [31:0] v2;
            rd(3'd0, v2);
            chk("R5 advancing", {31'h0, v2 > v}, 32'h1);
        end

        // R6: locked configuration
        cur_req = "R6";
        wr(3'd2, 32'd5); wr(3'd3, 32'd7); wr(3'd4, 32'h0); wr(3'd5, 32'h0);
        rd(3'd2, v); chk("R6 period lo locked", v, 32'd300);
        rd(3'd3, v); chk("R6 period hi locked", v, 32'd0);
        rd(3'd5, v); chk("R6 global locked", v, 32'hB);

        // R7: service restarts count
        cur_req = "R7";
        wr(3'd6, {K1, 16'h0}); wr(3'd6, {K2, 16'h0});
        rd(3'd0, v); chk("R7 count restarted", {31'h0, v < 5}, 32'h1);

        // R8: broken service sequence does not restart
        cur_req = "R8";
        wr(3'd6, {K1, 16'h0}); wr(3'd6, {16'h1111, 16'h0}); wr(3'd6, {K2, 16'h0});
        rd(3'd0, v); chk("R8 count kept running", {31'h0, v >= 6}, 32'h1);

        // R9: timeout
        cur_req = "R9";
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (wd_reset_o) pulses++;
        end
        chk("R9 single pulse", pulses, 32'd1);
        chk("R9 flag set", {31'h0, wd_timeout_o}, 32'h1);

        // R10: expired state
        cur_req = "R10";
        rd(3'd0, v); chk("R10 frozen count", v, 32'd300);
        wr(3'd6, {K1, 16'h0}); wr(3'd6, {K2, 16'h0});
        rd(3'd0, v); chk("R10 keys ignored", v, 32'd300);
        rd(3'd6, v); chk("R10 ctl read", v, 32'hC000);

        // R11: flag clear
        cur_req = "R11";
        wr(3'd6, 32'h0000_4000); rd(3'd6, v); chk("R11 no clear", v, 32'hC000);
        wr(3'd6, 32'h0000_8000); rd(3'd6, v); chk("R11 cleared", v, 32'h4000);

        // R5: bad configuration holds count
        cur_req = "R5";
        do_reset();
        wr(3'd4, 32'h40); wr(3'd0, 32'hFFFF_FFF0); wr(3'd2, 32'd5); wr(3'd3, 32'd1);
        wr(3'd6, {K1, 16'h4000}); wr(3'd6, {K2, 16'h4000});
        repeat (5) @(posedge clk);
        rd(3'd0, v); chk("R5 gated by config", v, 32'hFFFF_FFF0);

        // R5/R9: carry across halves and 64-bit match
        do_reset();
        wr(3'd4, 32'h40); wr(3'd5, 32'hB);
        wr(3'd0, 32'hFFFF_FFF0); wr(3'd2, 32'd5); wr(3'd3, 32'd1);
        wr(3'd6, {K1, 16'h4000}); wr(3'd6, {K2, 16'h4000});
        repeat (60) @(posedge clk);
        rd(3'd1, v); chk("R5 carry into high", v, 32'd1);
        rd(3'd0, v); chk("R9 stops at period", v, 32'd5);
        chk("R9 flag 64-bit", {31'h0, wd_timeout_o}, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule